// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Controller

This block is the interrupt acknowledge logic for a small 8-bit processor core. Thirteen request lines come in, one per source. Each source has its own enable bit and its own priority bit, and a single global enable gates all of them. On every instruction-boundary strobe from the core, the block picks at most one winning source. It then performs the hardware call. First it streams the two bytes of the current program counter to the stack over a valid/ready port, low byte first. Then it pulses an acknowledge together with a program-counter load of the winner's vector address.

The block tracks which of the two priority levels is in service. Only the core's return-from-interrupt strobe releases a level. A plain return strobe restores the program counter from the stack but leaves the level marked, so requests of that level and below stay blocked. Either return strobe pulls two bytes from a valid/ready pop port, high byte first, and issues a program-counter load of the assembled address.

For request flags, the block only tells the outside which flags to clear. It asks for a clear on acknowledge only for the two external inputs, and only when they are in edge mode. All other flags, including the serial and timer-2 flags, are left for software to clear. The status word is never saved.

Back-pressure rules:
- The push port holds `push_valid` and `push_data` steady until `push_ready` is seen.
- The pop port asserts `pop_ready` and waits as long as needed for `pop_valid`.
- Neither port ever drops a byte.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The vector for source index i (0..12) is 8*i+3 for i below 6, 0x43+8*(i-6) for i from 6 to 11, and 0x7B for index 12 (power-down wake-up). Index 0 is external input 0 and index 2 is external input 1.
- R2: A source competes only when its request, its enable and the global enable are all 1, and only on a cycle where `instr_bnd` is 1. Without a winner, `busy` stays 0.
- R3: A source whose priority bit is 1 beats any source whose priority bit is 0. Within one level, the lowest index wins.
- R4: While the high level is in service nothing is accepted. While only the low level is in service, only high-level sources are accepted.
- R5: An accepted call pushes the `pc_now` value seen at the boundary as two bytes, low then high. Each byte is held stable on `push_data` with `push_valid` high until `push_ready` is 1.
- R6: In the cycle after the second byte is accepted, `ack` and `pc_load` pulse for one cycle with `pc_target` equal to the winner's vector, and the winner's level becomes in service.
- R7: In the cycle after the boundary, a newly active eligible high-level source replaces a low-level winner. A later source of the same level does not replace it.
- R8: With `ack`, `flag_clr` has bit 0 set only when source 0 wins and `ext_edge[0]` is 1, and bit 2 set only when source 2 wins and `ext_edge[1]` is 1. Every other bit is 0.
- R9: A `ret_reti` strobe reads two bytes from the pop port, high then low, pulses `pc_load` without `ack` with that address, and releases the highest level in service.
- R10: A `ret_plain` strobe performs the same pop and load but leaves both levels' in-service state unchanged.
- R11: Strobes are acted on only while `busy` is 0. A return strobe in the same cycle as a winning boundary takes precedence over the call.
- R12: After reset, `busy`, `ack`, `pc_load`, `push_valid` and `pop_ready` are 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 13 | Request lines by source index (index 12 is the wake event) |
| src_en | input | 13 | Per-source enable |
| src_hi | input | 13 | Per-source priority, 1 = high level |
| glob_en | input | 1 | Global enable |
| ext_edge | input | 2 | Edge mode for external inputs 0 and 1 |
| instr_bnd | input | 1 | Instruction boundary strobe |
| pc_now | input | 16 | Program counter of the interrupted flow |
| push_valid | output | 1 | Stack push byte valid |
| push_ready | input | 1 | Stack accepts byte |
| push_data | output | 8 | Byte to push |
| ret_reti | input | 1 | Return-from-interrupt strobe |
| ret_plain | input | 1 | Plain return strobe |
| pop_valid | input | 1 | Popped byte valid |
| pop_ready | output | 1 | Block waits for popped byte |
| pop_data | input | 8 | Popped byte |
| pc_load | output | 1 | Program counter load pulse |
| pc_target | output | 16 | Address to load |
| ack | output | 1 | Interrupt acknowledge pulse |
| flag_clr | output | 13 | Hardware flag clear requests, valid with ack |
| busy | output | 1 | Sequence in progress |

## Verification
Random request, enable and priority patterns are run against a bench arbitration model. The bench tracks the in-service levels across calls, RETI and plain returns, so that blocking by level is told apart from plain priority ordering. Directed cases raise a second request one cycle after the boundary, once at a higher level (it must win) and once at the same level (it must not). Other directed cases follow a plain return with a same-level request that must stay blocked, send a return and a boundary together, and toggle external-input edge mode to separate cleared flags from kept ones. Random stalls on both stack ports check that bytes are held stable and kept in order.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC   = 13;
  localparam int IDXW   = $clog2(NSRC);
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;
  localparam int EXT0_IDX = 0;
  localparam int EXT1_IDX = 2;
  localparam int WAKE_IDX = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONF, ST_PUSH_LO, ST_PUSH_HI, ST_CALL,
    ST_POP_HI, ST_POP_LO, ST_RLOAD
  } ivc_state_e;

  // vector address by source index
  function automatic logic [PC_W-1:0] vec_of(input logic [IDXW-1:0] idx);
    logic [IDXW-1:0] off;
    if (idx == IDXW'(WAKE_IDX)) return PC_W'(16'h007B);
    if (idx < IDXW'(6)) return PC_W'({idx, 3'b011});
    off = idx - IDXW'(6);
    return PC_W'(16'h0043) + PC_W'({off, 3'b000});
  endfunction
endpackage

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int IW = IDXW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  hi,
  input  logic          glob_en,
  input  logic          blk_hi,
  input  logic          blk_lo,
  output logic          win_valid,
  output logic          win_lvl,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0] live, hi_ok, lo_ok;

  assign live  = req & en & {N{glob_en}};
  assign hi_ok = blk_hi ? '0 : (live & hi);
  assign lo_ok = blk_lo ? '0 : (live & ~hi);

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = 1'b0;
    win_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lo_ok[i]) begin
        win_valid = 1'b1;
        win_lvl   = 1'b0;
        win_idx   = IW'(i);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_ok[i]) begin
        win_valid = 1'b1;
        win_lvl   = 1'b1;
        win_idx   = IW'(i);
      end
    end
  end

  // R4: a grant never lands on a blocked level
  a_r4_level_block: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_lvl ? !blk_hi : !blk_lo));
  // R2: the granted source is really live
  a_r2_live_grant: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req[win_idx] && en[win_idx] && glob_en && (hi[win_idx] == win_lvl)));
endmodule

// File: rtl/ivc_level_track.sv
module ivc_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic set_lvl,
  input  logic clr_en,
  output logic blk_hi,
  output logic blk_lo
);
  logic [1:0] inprog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inprog <= 2'b00;
    end else if (set_en) begin
      inprog[set_lvl] <= 1'b1;
    end else if (clr_en) begin
      if (inprog[1]) inprog[1] <= 1'b0;
      else           inprog[0] <= 1'b0;
    end
  end

  assign blk_hi = inprog[1];
  assign blk_lo = |inprog;

  // R6: acknowledge marks the winner's level
  a_r6_level_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> inprog[$past(set_lvl)]);
  // R9: release removes the top level first
  a_r9_release_top: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && inprog[1]) |=> (!inprog[1] && inprog[0] == $past(inprog[0])));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en));
endmodule

// File: rtl/ivc_sequencer.sv
module ivc_sequencer
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_bnd,
  input  logic              ret_reti,
  input  logic              ret_plain,
  input  logic              win_valid,
  input  logic              win_lvl,
  input  logic [IDXW-1:0]   win_idx,
  input  logic [PC_W-1:0]   pc_now,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BYTE_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [BYTE_W-1:0] pop_data,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_target,
  output logic              ack,
  output logic [IDXW-1:0]   ack_idx,
  output logic              ack_lvl,
  output logic              release_lvl,
  output logic              busy
);
  ivc_state_e        st;
  logic [IDXW-1:0]   cand_idx;
  logic              cand_lvl;
  logic [PC_W-1:0]   pc_cap;
  logic [PC_W-1:0]   pop_buf;
  logic              is_reti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cand_idx <= '0;
      cand_lvl <= 1'b0;
      pc_cap   <= '0;
      pop_buf  <= '0;
      is_reti  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (ret_reti || ret_plain) begin
            is_reti <= ret_reti;
            st      <= ST_POP_HI;
          end else if (instr_bnd && win_valid) begin
            cand_idx <= win_idx;
            cand_lvl <= win_lvl;
            pc_cap   <= pc_now;
            st       <= ST_CONF;
          end
        end
        ST_CONF: begin
          // a high-level request arriving now overrides a low-level pick
          if (win_valid && win_lvl && !cand_lvl) begin
            cand_idx <= win_idx;
            cand_lvl <= 1'b1;
          end
          st <= ST_PUSH_LO;
        end
        ST_PUSH_LO: if (push_ready) st <= ST_PUSH_HI;
        ST_PUSH_HI: if (push_ready) st <= ST_CALL;
        ST_CALL:    st <= ST_IDLE;
        ST_POP_HI: begin
          if (pop_valid) begin
            pop_buf[PC_W-1:BYTE_W] <= pop_data;
            st <= ST_POP_LO;
          end
        end
        ST_POP_LO: begin
          if (pop_valid) begin
            pop_buf[BYTE_W-1:0] <= pop_data;
            st <= ST_RLOAD;
          end
        end
        ST_RLOAD:   st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign push_valid  = (st == ST_PUSH_LO) || (st == ST_PUSH_HI);
  assign push_data   = (st == ST_PUSH_HI) ? pc_cap[PC_W-1:BYTE_W] : pc_cap[BYTE_W-1:0];
  assign pop_ready   = (st == ST_POP_HI) || (st == ST_POP_LO);
  assign ack         = (st == ST_CALL);
  assign pc_load     = (st == ST_CALL) || (st == ST_RLOAD);
  assign pc_target   = (st == ST_CALL) ? vec_of(cand_idx) : pop_buf;
  assign ack_idx     = cand_idx;
  assign ack_lvl     = cand_lvl;
  assign release_lvl = (st == ST_RLOAD) && is_reti;

  // R5: push byte held under back-pressure
  a_r5_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  // R6: acknowledge is a single-cycle load
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R9: pop port waits for data
  a_r9_pop_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |=> pop_ready);
  // R11: the two ports are never active together
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_ready));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   src_hi,
  input  logic              glob_en,
  input  logic [1:0]        ext_edge,
  input  logic              instr_bnd,
  input  logic [PC_W-1:0]   pc_now,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BYTE_W-1:0] push_data,
  input  logic              ret_reti,
  input  logic              ret_plain,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [BYTE_W-1:0] pop_data,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_target,
  output logic              ack,
  output logic [NSRC-1:0]   flag_clr,
  output logic              busy
);
  logic            blk_hi, blk_lo;
  logic            win_valid, win_lvl;
  logic [IDXW-1:0] win_idx;
  logic [IDXW-1:0] ack_idx;
  logic            ack_lvl;
  logic            release_lvl;

  ivc_arbiter #(.N(NSRC), .IW(IDXW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(req), .en(src_en), .hi(src_hi), .glob_en(glob_en),
    .blk_hi(blk_hi), .blk_lo(blk_lo),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  ivc_level_track u_lvl (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack), .set_lvl(ack_lvl), .clr_en(release_lvl),
    .blk_hi(blk_hi), .blk_lo(blk_lo)
  );

  ivc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .instr_bnd(instr_bnd), .ret_reti(ret_reti), .ret_plain(ret_plain),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx),
    .pc_now(pc_now),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .pc_load(pc_load), .pc_target(pc_target),
    .ack(ack), .ack_idx(ack_idx), .ack_lvl(ack_lvl),
    .release_lvl(release_lvl), .busy(busy)
  );

  // only edge-mode external inputs get a hardware clear
  always_comb begin
    flag_clr = '0;
    if (ack) begin
      if (ack_idx == IDXW'(EXT0_IDX) && ext_edge[0]) flag_clr[EXT0_IDX] = 1'b1;
      if (ack_idx == IDXW'(EXT1_IDX) && ext_edge[1]) flag_clr[EXT1_IDX] = 1'b1;
    end
  end

  // R8: clears only with ack and at most one bit
  a_r8_clr_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |-> (ack && $onehot0(flag_clr)));
  // R10: a return load never carries an acknowledge
  a_r10_ret_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !ack) |-> !push_valid);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] req = '0, src_en = '0, src_hi = '0;
  logic        glob_en = 1'b0;
  logic [1:0]  ext_edge = '0;
  logic        instr_bnd = 1'b0;
  logic [15:0] pc_now = '0;
  logic        push_valid, push_ready = 1'b0;
  logic [7:0]  push_data;
  logic        ret_reti = 1'b0, ret_plain = 1'b0;
  logic        pop_valid = 1'b0, pop_ready;
  logic [7:0]  pop_data = '0;
  logic        pc_load, ack, busy;
  logic [15:0] pc_target;
  logic [12:0] flag_clr;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0] m_ip = 2'b00;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .src_en(src_en), .src_hi(src_hi),
    .glob_en(glob_en), .ext_edge(ext_edge), .instr_bnd(instr_bnd), .pc_now(pc_now),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .ret_reti(ret_reti), .ret_plain(ret_plain), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_data(pop_data), .pc_load(pc_load),
    .pc_target(pc_target), .ack(ack), .flag_clr(flag_clr), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int idx);
    case (idx)
      0: return 16'h0003;  1: return 16'h000B;  2: return 16'h0013;
      3: return 16'h001B;  4: return 16'h0023;  5: return 16'h002B;
      6: return 16'h0043;  7: return 16'h004B;  8: return 16'h0053;
      9: return 16'h005B; 10: return 16'h0063; 11: return 16'h006B;
      default: return 16'h007B;
    endcase
  endfunction

  // returns -1 for no winner, else idx + 16*level
  function automatic int model_pick(input logic [12:0] r, input logic [12:0] e,
                                    input logic [12:0] h, input logic g, input logic [1:0] ip);
    if (!g) return -1;
    if (!ip[1])
      for (int i = 0; i < 13; i++) if (r[i] && e[i] && h[i]) return i + 16;
    if (ip == 2'b00)
      for (int i = 0; i < 13; i++) if (r[i] && e[i] && !h[i]) return i;
    return -1;
  endfunction

  // boundary pulse; returns with the cycle after it current (CONF if accepted)
  task automatic boundary(input string tag, input bit expect_busy);
    @(negedge clk);
    instr_bnd = 1'b1;
    @(negedge clk);
    instr_bnd = 1'b0;
    chk(tag, busy, expect_busy);
  endtask

  // finishes a call after the boundary: R5 push, R6 ack, R1 vector, R8 clear
  task automatic run_call(input int exp_idx, input int lvl, input logic [15:0] pc);
    int k = 0;
    bit done = 0;
    int guard = 0;
    logic [12:0] eclr;
    eclr = '0;
    if (exp_idx == 0 && ext_edge[0]) eclr[0] = 1'b1;
    if (exp_idx == 2 && ext_edge[1]) eclr[2] = 1'b1;
    while (!done && guard < 80) begin
      @(negedge clk);
      guard++;
      if (ack) begin
        chk("R1 vector", pc_target, exp_vec(exp_idx));
        chk("R6 load with ack", pc_load, 1);
        chk("R6 both bytes before ack", k, 2);
        chk("R8 flag clear", flag_clr, eclr);
        push_ready = 1'b0;
        instr_bnd = 1'b0;
        done = 1;
      end else if (push_valid) begin
        chk("R5 push byte", push_data, (k == 0) ? pc[7:0] : pc[15:8]);
        push_ready = ($urandom % 2) == 1;
        if (push_ready) k++;
        instr_bnd = ($urandom % 2) == 1;
      end else begin
        push_ready = 1'b0;
      end
    end
    chk("R6 ack seen", done, 1);
    m_ip[lvl] = 1'b1;
    @(negedge clk);
    chk("R11 no call while busy", busy, 0);
  endtask

  // R9 / R10: return with pop stream
  task automatic do_ret(input bit reti);
    logic [15:0] addr;
    int k = 0;
    bit done = 0;
    int guard = 0;
    addr = 16'($urandom);
    @(negedge clk);
    ret_reti = reti;
    ret_plain = !reti;
    @(negedge clk);
    ret_reti = 1'b0;
    ret_plain = 1'b0;
    while (!done && guard < 80) begin
      if (pc_load) begin
        chk(reti ? "R9 popped address" : "R10 popped address", pc_target, addr);
        chk(reti ? "R9 no ack" : "R10 no ack", ack, 0);
        chk("R9 both bytes", k, 2);
        done = 1;
      end else if (pop_ready) begin
        pop_valid = ($urandom % 2) == 1;
        pop_data = (k == 0) ? addr[15:8] : addr[7:0];
        if (pop_valid) k++;
      end else begin
        pop_valid = 1'b0;
      end
      if (!done) begin
        @(negedge clk);
        guard++;
      end
    end
    pop_valid = 1'b0;
    chk("R9 return done", done, 1);
    if (reti) begin
      if (m_ip[1]) m_ip[1] = 1'b0;
      else m_ip[0] = 1'b0;
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pick;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 ack", ack, 0);
    chk("R12 pc_load", pc_load, 0);
    chk("R12 push_valid", push_valid, 0);
    chk("R12 pop_ready", pop_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: global enable off, then no boundary
    req = 13'h1FFF; src_en = 13'h1FFF; src_hi = '0;
    boundary("R2 global enable gates", 0);
    glob_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no sampling without boundary", busy, 0);
    src_en = 13'h1FFE;
    req = 13'h0001;
    boundary("R2 disabled source ignored", 0);

    // R7: late high-level request wins
    src_en = 13'h1FFF;
    req = 13'h0020; src_hi = 13'h0080; pc_now = 16'h1234;
    boundary("R7 low pick accepted", 1);
    req = 13'h00A0;
    run_call(7, 1, 16'h1234);
    do_ret(1);
    // R7: late same-level request does not
    req = 13'h0020; src_hi = '0; pc_now = 16'hBEEF;
    boundary("R7 low pick", 1);
    req = 13'h0022;
    run_call(5, 0, 16'hBEEF);
    do_ret(1);

    // R10: plain return keeps level blocked
    req = 13'h0008; src_hi = '0; pc_now = 16'h0F0F;
    boundary("R3 call", 1);
    run_call(3, 0, 16'h0F0F);
    do_ret(0);
    req = 13'h0010;
    boundary("R10 same level still blocked", 0);
    src_hi = 13'h0010;
    boundary("R4 high level passes low service", 1);
    run_call(4, 1, 16'h0F0F);
    req = 13'h1FFF;
    boundary("R4 all blocked under high service", 0);
    do_ret(1);
    do_ret(1);
    chk("R9 levels released", m_ip, 0);

    // R11: return beats boundary
    req = 13'h0001; src_hi = '0;
    @(negedge clk);
    instr_bnd = 1'b1; ret_plain = 1'b1;
    @(negedge clk);
    instr_bnd = 1'b0; ret_plain = 1'b0;
    chk("R11 return precedence", {pop_ready, push_valid}, 2'b10);
    begin
      logic [15:0] a2;
      a2 = 16'hA55A;
      pop_valid = 1'b1; pop_data = a2[15:8];
      @(negedge clk); pop_data = a2[7:0];
      @(negedge clk); pop_valid = 1'b0;
      chk("R11 return load", pc_target, a2);
      chk("R11 return load pulse", pc_load, 1);
    end

    // R8: external input 0 in level then edge mode, input 1 edge
    ext_edge = 2'b00; req = 13'h0001; pc_now = 16'h2222;
    boundary("R8 level call", 1);
    run_call(0, 0, 16'h2222);
    do_ret(1);
    ext_edge = 2'b11;
    boundary("R8 edge call", 1);
    run_call(0, 0, 16'h2222);
    do_ret(1);
    req = 13'h0004;
    boundary("R8 edge call ext1", 1);
    run_call(2, 0, 16'h2222);
    do_ret(1);
    req = 13'h1000; src_hi = 13'h1000;
    boundary("R1 wake call", 1);
    run_call(12, 1, 16'h2222);
    do_ret(1);

    // random phase: R1..R6, R8
    for (int it = 0; it < 300; it++) begin
      req = 13'($urandom & $urandom);
      src_en = 13'($urandom | $urandom);
      src_hi = 13'($urandom);
      glob_en = ($urandom % 8) != 0;
      ext_edge = 2'($urandom);
      pc_now = 16'($urandom);
      pick = model_pick(req, src_en, src_hi, glob_en, m_ip);
      boundary("R3 accept decision", pick >= 0);
      if (pick >= 0) run_call(pick % 16, pick / 16, pc_now);
      if (m_ip != 0 && ($urandom % 3) != 0) do_ret(1);
      else if (($urandom % 6) == 0) do_ret(0);
    end
    finish_run();
  end
endmodule